// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of upcoming instruction bytes between a bus-fetch port and an instruction decoder. It holds up to six bytes. It requests code words from a 16-bit memory port on its own whenever the store has room for a full word. The decoder takes the bytes one at a time, and for every take it marks whether the byte starts a new instruction.

The memory port returns a 16-bit word. The fetch address decides how much of that word is kept. At an even address both byte lanes are stored. At an odd address only the upper lane is stored, which brings the fetch pointer back to word alignment. After a taken branch, the decoder pulses a flush with the branch target. The flush empties the store, drops any word that returns in the same cycle, and moves fetching to the target.

A two-bit status code reports each take and each flush. The code appears on the clock cycle after the action.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty, `byte_valid` is 0, `qstat` is 00, and `fetch_req` is 1 with `fetch_addr` equal to the `RESET_ADDR` parameter.
- R2: `fetch_req` is 1 exactly when at least two of the six slots are free and `flush` is 0. A `fetch_ack` counts only in a cycle where `fetch_req` is 1.
- R3: A counted fetch at an even address stores two bytes. `fetch_data[7:0]` (the even byte) goes in first and `fetch_data[15:8]` second. The fetch address then advances by 2.
- R4: A counted fetch at an odd address stores only `fetch_data[15:8]`, and the fetch address advances by 1.
- R5: Bytes leave in the order they were stored. `byte_out` shows the oldest byte while `byte_valid` is 1. `byte_valid` is 0 when the queue is empty, and a `byte_take` while empty changes nothing.
- R6: `flush` empties the queue, so `byte_valid` is 0 from the next cycle. It sets the next fetch address to `flush_addr`, and it discards both a take and any fetch data in the same cycle.
- R7: `qstat` in the cycle after an action reads 10 for a flush. It reads 01 for a take with `byte_first` = 1, and 11 for a take with `byte_first` = 0. It reads 00 when neither happened.
- R8: Takes proceed while a fetch request waits for its acknowledge. A take and a fetch in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_addr | input | AW | New fetch address used with flush |
| fetch_req | output | 1 | Code fetch request |
| fetch_addr | output | AW | Byte address of the requested fetch |
| fetch_ack | input | 1 | Fetch data valid this cycle |
| fetch_data | input | 16 | Fetched word, even byte in bits 7:0 |
| byte_valid | output | 1 | Queue holds at least one byte |
| byte_out | output | 8 | Oldest queued byte |
| byte_take | input | 1 | Consumer removes the oldest byte |
| byte_first | input | 1 | The taken byte is the first byte of an instruction |
| qstat | output | 2 | Status of the previous cycle's queue action |

## Verification
The outputs `fetch_req`, `fetch_addr`, `byte_valid` and `byte_out` follow the queue state and the inputs of the same cycle. A stored byte or an emptying therefore shows one rising edge after the acknowledge, take or flush that caused it. The bench drives inputs on the falling edge and checks these outputs a short delay later in the same half-cycle. `qstat` is registered, so the bench keeps the code it expects for a cycle and compares it at the next falling edge, one edge after the action. A model queue, filled at each counted acknowledge and emptied at each take, supplies the expected byte order.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [15:0]   fetch_data,
  output logic          byte_valid,
  output logic [7:0]    byte_out,
  input  logic          byte_take,
  input  logic          byte_first,
  output logic [1:0]    qstat
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic [AW-1:0] faddr;

  assign fetch_req  = !flush && (cnt <= CW'(DEPTH - 2));
  assign fetch_addr = faddr;
  assign byte_valid = cnt != '0;
  assign byte_out   = mem[rd_p];

  wire          wr_go = fetch_ack && fetch_req;
  wire          odd   = faddr[0];
  wire          rd_go = byte_take && byte_valid && !flush;
  wire [CW-1:0] n_wr  = wr_go ? (odd ? CW'(1) : CW'(2)) : '0;
  wire [CW-1:0] n_rd  = rd_go ? CW'(1) : '0;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (odd) mem[wr_p] <= fetch_data[15:8];
      else begin
        mem[wr_p]         <= fetch_data[7:0];
        mem[adv(wr_p, 1)] <= fetch_data[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt   <= '0;
      faddr <= RESET_ADDR;
      qstat <= 2'b00;
    end else begin
      if (flush) begin
        rd_p  <= '0;
        wr_p  <= '0;
        cnt   <= '0;
        faddr <= flush_addr;
        qstat <= 2'b10;
      end else begin
        wr_p  <= adv(wr_p, int'(n_wr));
        rd_p  <= rd_go ? adv(rd_p, 1) : rd_p;
        cnt   <= cnt + n_wr - n_rd;
        if (wr_go) faddr <= faddr + (odd ? AW'(1) : AW'(2));
        qstat <= rd_go ? (byte_first ? 2'b01 : 2'b11) : 2'b00;
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_no_req_when_tight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(DEPTH - 2)) |-> !fetch_req);
  assert_even_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ack && fetch_req && !fetch_addr[0]) |=> fetch_addr == $past(fetch_addr) + AW'(2));
  assert_odd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ack && fetch_req && fetch_addr[0]) |=> fetch_addr == $past(fetch_addr) + AW'(1));
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!byte_valid && fetch_addr == $past(flush_addr)));
  assert_flush_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> qstat == 2'b10);
  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !byte_take) |=> qstat == 2'b00);
endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] RST_A = 20'hFFFF0;

  logic clk = 0, rst_n = 0;
  logic flush = 0, fetch_ack = 0, byte_take = 0, byte_first = 0;
  logic [19:0] flush_addr = '0;
  logic [15:0] fetch_data = '0;
  logic fetch_req, byte_valid;
  logic [19:0] fetch_addr;
  logic [7:0] byte_out;
  logic [1:0] qstat;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] sb[$];
  logic [19:0] exp_addr;
  logic [1:0] exp_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .byte_valid(byte_valid), .byte_out(byte_out),
    .byte_take(byte_take), .byte_first(byte_first), .qstat(qstat));

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      summary();
    end
  end

  // driver and monitor for one cycle; called at a falling edge
  task automatic cyc(input bit ack_en, input bit tk, input bit fst, input bit fl,
                     input logic [19:0] fa);
    bit exp_req, rd;
    chk(qstat == exp_stat, "R7", qstat, exp_stat);
    chk(byte_valid == (sb.size() != 0), "R5", byte_valid, sb.size() != 0);
    flush = fl; flush_addr = fa; byte_take = tk; byte_first = fst; fetch_ack = ack_en;
    fetch_data = {mbyte(fetch_addr | 20'h1), mbyte(fetch_addr & ~20'h1)};
    #1;
    exp_req = !fl && (sb.size() <= 4);
    chk(fetch_req == exp_req, "R2", fetch_req, exp_req);
    if (exp_req)
      chk(fetch_addr == exp_addr, exp_addr[0] ? "R4" : "R3", fetch_addr, exp_addr);
    rd = tk && sb.size() != 0 && !fl;
    if (rd) begin
      chk(byte_out == sb[0], (exp_req && !ack_en) ? "R8" : "R5", byte_out, sb[0]);
      void'(sb.pop_front());
    end
    exp_stat = fl ? 2'b10 : (rd ? (fst ? 2'b01 : 2'b11) : 2'b00);
    if (fl) begin
      sb.delete();
      exp_addr = fa;
    end else if (ack_en && exp_req) begin
      if (exp_addr[0]) begin
        sb.push_back(mbyte(exp_addr));
        exp_addr = exp_addr + 1;
      end else begin
        sb.push_back(mbyte(exp_addr));
        sb.push_back(mbyte(exp_addr + 1));
        exp_addr = exp_addr + 2;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(fetch_req == 1'b1, "R1", fetch_req, 1);
    chk(fetch_addr == RST_A, "R1", fetch_addr, RST_A);
    chk(byte_valid == 1'b0, "R1", byte_valid, 0);
    chk(qstat == 2'b00, "R1", qstat, 0);
    exp_addr = RST_A;
    exp_stat = 2'b00;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0);             // R8: take while the request waits
    cyc(1, 1, 0, 0, 0);             // R8: take and fetch together
    repeat (4) cyc(1, 0, 0, 0, 0);  // fill to six, R2 request drops
    cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 20'h00233);     // R6 flush to odd target
    cyc(1, 0, 0, 0, 0);             // R4 one byte
    cyc(1, 0, 0, 0, 0);             // R3 two bytes
    cyc(0, 1, 1, 0, 0);
    cyc(1, 1, 0, 1, 20'h00400);     // R6 flush drops ack and take
    cyc(0, 1, 1, 0, 0);             // R5 take while empty
    cyc(1, 0, 0, 0, 0);
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[1], lf[2], lf[3], lf[7:4] == 4'd0, {4'h0, lf});
    end
    cyc(0, 0, 0, 0, 0);
    summary();
  end
endmodule